// File: doc/BRIEF.md
# MFM Bit-Cell Data Separator

This block turns the read line of a floppy drive into a stream of bit-cell values. The line idles high. A flux transition shows up as a short low-going pulse at the start of a bit cell. The line then floats back high before the cell is over. The block brings the line into the system clock domain and finds each falling edge. It recovers the cell timing from the data itself: a free-running cell counter is pulled back to zero by every detected edge. The counter only has to stay accurate across the few edge-free cells between transitions.

For every completed cell the block presents one bit: 1 if a falling edge landed in that cell, 0 if not. A one-cycle strobe marks each bit. The decision rests on the edge alone and never on the line level late in the cell, because the low part of a pulse covers only about the first third of the nominal 2 µs cell. A stretched copy of each detected edge is provided for monitoring. Decoding of MFM data and clock bits, sync search and sector framing are left to the logic downstream.

The cell timer is a three-state machine:
- ST_WARM: the first cell after reset.
- ST_EARLY: the first half of a cell.
- ST_LATE: the second half of a cell.

Its named transitions are:
- warm_done: ST_WARM to ST_EARLY when the counter reaches its last count with no edge. No bit is emitted.
- warm_resync: ST_WARM to ST_WARM on an edge. The counter returns to 0.
- early_resync: ST_EARLY to ST_EARLY on an edge. The counter returns to 0 and the seen flag is set.
- half_cross: ST_EARLY to ST_LATE when the counter passes half a cell.
- late_close: ST_LATE to ST_EARLY on an edge. The bit is emitted with the old flag, and the new cell starts with its flag set.
- cell_end: ST_LATE to ST_EARLY at the last count with no edge. The bit is emitted and the flag is cleared.

Top module: `mfm_cell_sep`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `bit_vld_o` and `bit_o` are 0 and `stretch_n_o` is 1.
- R2: A low level on `rd_n_i` passes through a two-stage synchroniser. A falling edge is recognised when the previous synchronised sample is 1 and the current one is 0. The first visible effect, `stretch_n_o` going to 0, appears after the third rising clock edge, counting the edge that first samples the low level.
- R3: With no edges on the line, after warm-up `bit_vld_o` pulses for exactly one cycle every CELL_CYC cycles, with `bit_o` = 0.
- R4: An edge detected while the cell counter is below CELL_CYC/2 restarts the cell at count 0 and marks it as seen. That cell's strobe then carries `bit_o` = 1, CELL_CYC cycles after the edge.
- R5: An edge detected while the counter is at CELL_CYC/2 or higher closes the current cell at once. The strobe carries that cell's previous seen value, and a new cell starts with its seen flag set. Two strobes are never closer than CELL_CYC/2+1 cycles.
- R6: When an edge is detected on the last count of a cell (CELL_CYC−1), only one strobe is produced for that cell. It carries the cell's old seen value, and the edge counts toward the following cell.
- R7: No strobe is produced during the first cell after reset. An edge during warm-up only restarts the warm-up count.
- R8: Each detected edge drives `stretch_n_o` low for exactly STRETCH_CYC cycles. A new edge during that time restarts the count.
- R9: Only falling edges count. A rising edge, or the line held low for many cells, adds no further marks.
- R10: `bit_o` keeps the value of the last strobe between strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_n_i | input | 1 | Raw read line, idle high, asynchronous |
| bit_o | output | 1 | Value of the most recently closed cell |
| bit_vld_o | output | 1 | One-cycle strobe for each closed cell |
| stretch_n_o | output | 1 | Active-low stretched copy of each detected edge |

## Verification
Two events can land in the same cycle: the natural end of a cell and an edge that closes it. The bench provokes this by spacing consecutive edges exactly one cell length apart, so that an edge is detected just as the counter sits on its last count. It also places edges one count either side of the half-cell boundary, so that the restart and early-close paths are both exercised. A behavioural reference model in the bench predicts, on every clock, whether a single strobe appears and which bit it carries. The bench compares this with the outputs; a doubled strobe or a lost edge shows up as a mismatch.

// File: rtl/mfm_sep_pkg.sv
package mfm_sep_pkg;

    // Phases of the recovered bit cell
    typedef enum logic [1:0] {
        ST_WARM  = 2'd0,   // first cell after reset, bit suppressed
        ST_EARLY = 2'd1,   // first half of a cell
        ST_LATE  = 2'd2    // second half of a cell
    } cell_st_e;

endpackage

// File: rtl/mfm_in_sync.sv
module mfm_in_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rd_n_i,
    output logic fall_o
);

    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] chain_q;
    logic         prev_q;

    // Reset to the idle (high) level so that no false edge appears
    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            chain_q <= {chain_q[MSB-1:0], rd_n_i};
            prev_q  <= chain_q[MSB];
        end
    end

    assign fall_o = prev_q & ~chain_q[MSB];

endmodule

// File: rtl/mfm_cell_timer.sv
module mfm_cell_timer
    import mfm_sep_pkg::*;
#(
    parameter int CELL_CYC = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic fall_i,
    output logic bit_o,
    output logic vld_o
);

    localparam int CNT_W = $clog2(CELL_CYC);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CELL_CYC - 1);
    localparam logic [CNT_W-1:0] HALF_PRE = CNT_W'(CELL_CYC / 2 - 1);

    cell_st_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic            seen_q, seen_d;
    logic            emit, emit_bit;
    logic            at_last;
    logic            vld_q, bit_q;

    assign at_last = (cnt_q == LAST_CNT);

    // Next state, counter and seen flag
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q + CNT_W'(1);
        seen_d   = seen_q;
        emit     = 1'b0;
        emit_bit = seen_q;
        unique case (state_q)
            ST_WARM: begin
                if (fall_i) begin                 // warm_resync
                    cnt_d  = '0;
                    seen_d = 1'b1;
                end else if (at_last) begin       // warm_done
                    cnt_d   = '0;
                    seen_d  = 1'b0;
                    state_d = ST_EARLY;
                end
            end
            ST_EARLY: begin
                if (fall_i) begin                 // early_resync
                    cnt_d  = '0;
                    seen_d = 1'b1;
                end else if (cnt_q == HALF_PRE) begin
                    state_d = ST_LATE;            // half_cross
                end
            end
            ST_LATE: begin
                if (fall_i) begin                 // late_close (wins over cell_end)
                    emit    = 1'b1;
                    cnt_d   = '0;
                    seen_d  = 1'b1;
                    state_d = ST_EARLY;
                end else if (at_last) begin       // cell_end
                    emit    = 1'b1;
                    cnt_d   = '0;
                    seen_d  = 1'b0;
                    state_d = ST_EARLY;
                end
            end
            default: begin
                state_d = ST_WARM;
                cnt_d   = '0;
                seen_d  = 1'b0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_WARM;
            cnt_q   <= '0;
            seen_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            seen_q  <= seen_d;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            bit_q <= 1'b0;
        end else begin
            vld_q <= emit;
            if (emit) bit_q <= emit_bit;
        end
    end

    assign vld_o = vld_q;
    assign bit_o = bit_q;

endmodule

// File: rtl/mfm_pulse_stretch.sv
module mfm_pulse_stretch #(
    parameter int HOLD_CYC = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic fall_i,
    output logic stretch_n_o
);

    localparam int HOLD_W = $clog2(HOLD_CYC + 1);

    logic [HOLD_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst)                left_q <= '0;
        else if (fall_i)        left_q <= HOLD_W'(HOLD_CYC);
        else if (left_q != '0)  left_q <= left_q - HOLD_W'(1);
    end

    assign stretch_n_o = (left_q == '0);

endmodule

// File: rtl/mfm_cell_sep.sv
module mfm_cell_sep #(
    parameter int CELL_CYC    = 100,
    parameter int STRETCH_CYC = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic rd_n_i,
    output logic bit_o,
    output logic bit_vld_o,
    output logic stretch_n_o
);

    localparam int SYNC_STAGES = 2;

    if (CELL_CYC < 4) begin : g_bad_cell
        initial $display("mfm_cell_sep: CELL_CYC must be at least 4");
    end

    logic edge_fall;

    mfm_in_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .rd_n_i (rd_n_i),
        .fall_o (edge_fall)
    );

    mfm_cell_timer #(.CELL_CYC(CELL_CYC)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .fall_i (edge_fall),
        .bit_o  (bit_o),
        .vld_o  (bit_vld_o)
    );

    mfm_pulse_stretch #(.HOLD_CYC(STRETCH_CYC)) u_stretch (
        .clk         (clk),
        .rst         (rst),
        .fall_i      (edge_fall),
        .stretch_n_o (stretch_n_o)
    );

endmodule

// File: rtl/mfm_cell_sep_chk.sv
module mfm_cell_sep_chk #(
    parameter int CELL_CYC    = 100,
    parameter int STRETCH_CYC = 40
) (
    input logic clk,
    input logic rst,
    input logic fall,
    input logic vld,
    input logic stretch_n
);

    localparam int CW   = $clog2(CELL_CYC + 1);
    localparam int SW   = $clog2(STRETCH_CYC + 2);
    localparam int HALF = CELL_CYC / 2;

    logic [CW-1:0] since_rst;
    logic [CW-1:0] gap;
    logic [SW-1:0] low_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
            gap       <= CW'(CELL_CYC);
            low_run   <= '0;
        end else begin
            if (since_rst != CW'(CELL_CYC)) since_rst <= since_rst + CW'(1);
            if (vld)                        gap <= '0;
            else if (gap != CW'(CELL_CYC))  gap <= gap + CW'(1);
            if (fall || stretch_n)          low_run <= '0;
            else                            low_run <= low_run + SW'(1);
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!vld && stretch_n)); // R1
    AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (rst) vld |=> !vld); // R3
    AST_VLD_GAP: assert property (@(posedge clk) disable iff (rst) vld |-> (gap >= CW'(HALF))); // R5
    AST_WARM_NO_VLD: assert property (@(posedge clk) disable iff (rst) (since_rst < CW'(CELL_CYC)) |-> !vld); // R7
    AST_FALL_STRETCH: assert property (@(posedge clk) disable iff (rst) fall |=> !stretch_n); // R8
    AST_STRETCH_LEN: assert property (@(posedge clk) disable iff (rst) $rose(stretch_n) |-> (low_run == SW'(STRETCH_CYC))); // R8

endmodule

bind mfm_cell_sep mfm_cell_sep_chk #(
    .CELL_CYC    (CELL_CYC),
    .STRETCH_CYC (STRETCH_CYC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .fall      (edge_fall),
    .vld       (bit_vld_o),
    .stretch_n (stretch_n_o)
);

// File: tb/mfm_cell_sep_tb.sv
`timescale 1ns/1ps
module mfm_cell_sep_tb;

    localparam int CELL  = 100;
    localparam int HOLD  = 40;
    localparam int WDOG  = 60000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rd_n = 1'b1;
    logic bit_o, bit_vld_o, stretch_n_o;

    always #2 clk = ~clk;   // 250 MHz

    mfm_cell_sep #(.CELL_CYC(CELL), .STRETCH_CYC(HOLD)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .rd_n_i      (rd_n),
        .bit_o       (bit_o),
        .bit_vld_o   (bit_vld_o),
        .stretch_n_o (stretch_n_o)
    );

    int    total = 0;
    int    bad   = 0;
    int    cyc   = 0;
    bit    done  = 0;
    string cur_req = "R3";

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference: input history as a queue, cell phase as integers
    bit q_hist[$];
    int m_pos, m_hold;
    bit m_warm, m_mark, e_vld, e_bit;

    always @(posedge clk) begin
        if (rst) begin
            q_hist = '{1'b1, 1'b1, 1'b1};
            m_pos = 0; m_hold = 0; m_warm = 1; m_mark = 0;
            e_vld = 0; e_bit = 0;
        end else begin
            bit f;
            f = q_hist[0] && !q_hist[1];   // older sample high, newer low
            e_vld = 0;
            if (m_warm) begin
                if (f) begin m_pos = 0; m_mark = 1; end
                else if (m_pos == CELL - 1) begin m_pos = 0; m_mark = 0; m_warm = 0; end
                else m_pos++;
            end else if (f) begin
                if (m_pos >= CELL / 2) begin e_vld = 1; e_bit = m_mark; end
                m_pos = 0; m_mark = 1;
            end else if (m_pos == CELL - 1) begin
                e_vld = 1; e_bit = m_mark; m_pos = 0; m_mark = 0;
            end else m_pos++;
            if (f) m_hold = HOLD;
            else if (m_hold > 0) m_hold--;
            void'(q_hist.pop_front());
            q_hist.push_back(rd_n);
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(bit_vld_o == e_vld, cur_req, "bit_vld_o", bit_vld_o, e_vld);
            check(bit_o == e_bit, "R10", "bit_o", bit_o, e_bit);
            check(stretch_n_o == (m_hold == 0), "R8", "stretch_n_o", stretch_n_o, m_hold == 0);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG && !done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Low pulse then high; edge-to-edge spacing is low_c + high_c
    task automatic pulse(input int low_c, input int high_c);
        @(negedge clk) rd_n = 1'b0;
        idle(low_c - 1);
        @(negedge clk) rd_n = 1'b1;
        idle(high_c - 1);
    endtask

    initial begin
        int vcount;
        int lat;
        // R1: reset state
        idle(5);
        check(bit_vld_o == 0 && bit_o == 0, "R1", "outputs in reset", bit_vld_o, 0);
        check(stretch_n_o == 1, "R1", "stretch in reset", stretch_n_o, 1);
        rst = 1'b0;
        @(negedge clk);
        check(bit_vld_o == 0 && stretch_n_o == 1, "R1", "first cycle after reset",
              bit_vld_o, 0);

        // R7: no strobe during warm-up, even with an edge in it
        cur_req = "R7";
        vcount = 0;
        for (int i = 0; i < CELL + 40; i++) begin
            if (i == 20) rd_n = 1'b0;
            if (i == 40) rd_n = 1'b1;
            @(negedge clk);
            if (bit_vld_o) vcount++;
        end
        check(vcount == 0, "R7", "strobes in warm-up", vcount, 0);

        // R3: quiet line gives a 0 strobe every cell
        cur_req = "R3";
        vcount = 0;
        for (int i = 0; i < 3 * CELL + 80; i++) begin
            @(negedge clk);
            if (bit_vld_o) begin
                vcount++;
                check(bit_o == 0, "R3", "quiet cell bit", bit_o, 0);
            end
        end
        check(vcount >= 3, "R3", "quiet strobes", vcount, 3);

        // R2: synchroniser latency seen on the stretch output
        cur_req = "R2";
        @(negedge clk) rd_n = 1'b0;
        lat = 0;
        while (stretch_n_o && lat < 10) begin @(negedge clk); lat++; end
        check(lat == 3, "R2", "edges to first effect", lat, 3);
        idle(17);
        @(negedge clk) rd_n = 1'b1;
        idle(180);

        // R4: ordinary spacings of 2, 3 and 4 cells
        cur_req = "R4";
        pulse(20, 180); pulse(20, 280); pulse(20, 380); pulse(20, 180);
        // R4 boundary: detection at count CELL/2-1 restarts the cell
        pulse(20, 30); pulse(20, 180);
        // R5 boundary: detection at count CELL/2 closes the cell
        cur_req = "R5";
        pulse(20, 31); pulse(20, 31); pulse(20, 130); pulse(20, 240);
        // R6: edges exactly one cell apart land on the last count
        cur_req = "R6";
        pulse(20, 80); pulse(20, 80); pulse(20, 80); pulse(20, 280);
        // R8: retrigger inside the stretch window
        cur_req = "R8";
        pulse(10, 20); pulse(10, 20); pulse(10, 250);
        // R9: long low level and the rising edge add nothing
        cur_req = "R9";
        vcount = 0;
        @(negedge clk) rd_n = 1'b0;
        for (int i = 0; i < 4 * CELL; i++) begin
            @(negedge clk);
            if (bit_vld_o && bit_o) vcount++;
        end
        rd_n = 1'b1;
        for (int i = 0; i < 3 * CELL; i++) begin
            @(negedge clk);
            if (bit_vld_o && bit_o) vcount++;
        end
        check(vcount == 1, "R9", "marked cells for one held low", vcount, 1);
        check(stretch_n_o == 1, "R9", "stretch after rising edge", stretch_n_o, 1);
        idle(20);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule